// File: doc/BRIEF.md
# Descriptor Condition Evaluation Unit

This block sits beside a descriptor-driven DMA channel and makes the three control decisions that follow the execution of one descriptor. It decides whether to raise an interrupt, whether the channel must stall on the current descriptor, and whether the command pointer steps to the next descriptor or jumps to the address held in the descriptor's dependent-address field. Each decision tests a condition over a 4-bit device status field. The condition is a mask-and-compare against a select register, and each decision has its own select register. A 2-bit mode field for each decision, taken from the descriptor command word, uses that condition as written, uses it inverted, forces the decision on, or turns it off.

The channel controller asserts `eval_i` for one cycle. On that edge it also presents the status, the three select registers, the command word, the current command pointer and the dependent address, and the block captures all of them. A two-state machine carries out the evaluation. `S_IDLE` moves to `S_DECIDE` on a strobe (transition EVAL_START). `S_DECIDE` stays in `S_DECIDE` when a further strobe arrives (EVAL_CHAIN) and returns to `S_IDLE` otherwise (EVAL_DONE). On the edge that leaves `S_DECIDE`, the registered outputs are written from the captured inputs. The interrupt is a one-cycle pulse. A sticky flag outside this block latches it.

Top module: `dce_unit`

## Requirements
- R1: After reset, `irq_o`, `wait_o` and `br_taken_o` are 0 and `next_ptr_o` is 0.
- R2: A condition is true when (status AND mask) equals (value AND mask). The mask is bits 19:16 of the select register and the value is bits 3:0. No other select bit affects the result.
- R3: The interrupt mode sits in command bits 5:4 and is encoded 0 = never, 1 = if condition true, 2 = if condition false, 3 = always. It is evaluated with the interrupt select register. `irq_o` is high for exactly one cycle, during the second cycle after the edge that samples the strobe.
- R4: The branch mode sits in command bits 3:2, uses the same encoding and is evaluated with the branch select register. When the branch is taken, `next_ptr_o` becomes the dependent address and `br_taken_o` becomes 1.
- R5: When the branch is not taken, `next_ptr_o` becomes the captured current pointer plus 16 and `br_taken_o` becomes 0.
- R6: The wait mode sits in command bits 1:0, uses the same encoding and is evaluated with the wait select register. `wait_o` shows the wait decision of the latest evaluation.
- R7: When the wait decision is true, no interrupt is raised, `next_ptr_o` becomes the captured current pointer, and `br_taken_o` keeps its previous value.
- R8: Without a strobe, `next_ptr_o`, `br_taken_o` and `wait_o` hold their values and `irq_o` stays 0, whatever the data inputs do.
- R9: Strobes on consecutive cycles are each evaluated from their own captured inputs. The results appear on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eval_i | input | 1 | Evaluate strobe; captures all data inputs |
| dev_stat_i | input | 4 | Device status bits tested by the conditions |
| irq_sel_i | input | 32 | Interrupt select register (mask 19:16, value 3:0) |
| br_sel_i | input | 32 | Branch select register (mask 19:16, value 3:0) |
| wait_sel_i | input | 32 | Wait select register (mask 19:16, value 3:0) |
| cmd_word_i | input | 16 | Descriptor command word holding the three mode fields |
| cur_ptr_i | input | 32 | Command pointer of the descriptor just executed |
| dep_addr_i | input | 32 | Dependent-address field, the branch target |
| irq_o | output | 1 | One-cycle interrupt pulse |
| wait_o | output | 1 | Channel stall decision |
| next_ptr_o | output | 32 | Next command pointer |
| br_taken_o | output | 1 | Branch-taken status bit |

## Verification
Every result is written two clock edges after the strobe is sampled: one edge captures the inputs and the next writes the outputs. The bench therefore drives the inputs on a falling edge, lets two rising edges pass, and samples on the falling edge that follows. Between the two rising edges it scrambles every data input, which shows that only the captured values count. The `irq_o` pulse width, the hold while idle and back-to-back strobes each get their own test, and each of these samples on the exact falling edge where its result is due.

// File: rtl/dce_pkg.sv
package dce_pkg;

    typedef enum logic [1:0] {
        MODE_NEVER    = 2'd0,
        MODE_IF_TRUE  = 2'd1,
        MODE_IF_FALSE = 2'd2,
        MODE_ALWAYS   = 2'd3
    } cond_mode_e;

    typedef enum logic {
        S_IDLE   = 1'b0,
        S_DECIDE = 1'b1
    } dce_state_e;

    localparam int unsigned NUM_DECISIONS = 3;
    localparam int unsigned DEC_IRQ       = 0;
    localparam int unsigned DEC_BRANCH    = 1;
    localparam int unsigned DEC_WAIT      = 2;
    localparam int unsigned MODE_W        = 2;

    // command-word position of the mode field for each decision
    function automatic int unsigned mode_lsb(input int unsigned dec);
        return (NUM_DECISIONS - 1 - dec) * MODE_W;
    endfunction

endpackage

// File: rtl/dce_cond_match.sv
module dce_cond_match #(
    parameter int unsigned STAT_W   = 4,
    parameter int unsigned SEL_W    = 32,
    parameter int unsigned MASK_LSB = 16,
    parameter int unsigned VAL_LSB  = 0
) (
    input  logic [STAT_W-1:0] stat_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic              match_o
);
    logic [STAT_W-1:0] mask;
    logic [STAT_W-1:0] value;

    always_comb begin
        mask    = sel_i[MASK_LSB +: STAT_W];
        value   = sel_i[VAL_LSB  +: STAT_W];
        match_o = ((stat_i & mask) == (value & mask));
    end
endmodule

// File: rtl/dce_mode_apply.sv
module dce_mode_apply
    import dce_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    input  logic              match_i,
    output logic              fire_o
);
    cond_mode_e mode;

    always_comb begin
        mode = cond_mode_e'(mode_i);
        unique case (mode)
            MODE_NEVER:    fire_o = 1'b0;
            MODE_IF_TRUE:  fire_o = match_i;
            MODE_IF_FALSE: fire_o = !match_i;
            MODE_ALWAYS:   fire_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/dce_ptr_next.sv
module dce_ptr_next #(
    parameter int unsigned PTR_W  = 32,
    parameter int unsigned STRIDE = 16
) (
    input  logic [PTR_W-1:0] cur_i,
    input  logic [PTR_W-1:0] dep_i,
    input  logic             take_i,
    output logic [PTR_W-1:0] ptr_o
);
    localparam logic [PTR_W-1:0] STEP = PTR_W'(STRIDE);

    always_comb begin
        ptr_o = take_i ? dep_i : (cur_i + STEP);
    end
endmodule

// File: rtl/dce_unit.sv
module dce_unit
    import dce_pkg::*;
#(
    parameter int unsigned STAT_W   = 4,
    parameter int unsigned SEL_W    = 32,
    parameter int unsigned CMD_W    = 16,
    parameter int unsigned PTR_W    = 32,
    parameter int unsigned STRIDE   = 16,
    parameter int unsigned MASK_LSB = 16,
    parameter int unsigned VAL_LSB  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_i,
    input  logic [STAT_W-1:0] dev_stat_i,
    input  logic [SEL_W-1:0]  irq_sel_i,
    input  logic [SEL_W-1:0]  br_sel_i,
    input  logic [SEL_W-1:0]  wait_sel_i,
    input  logic [CMD_W-1:0]  cmd_word_i,
    input  logic [PTR_W-1:0]  cur_ptr_i,
    input  logic [PTR_W-1:0]  dep_addr_i,
    output logic              irq_o,
    output logic              wait_o,
    output logic [PTR_W-1:0]  next_ptr_o,
    output logic              br_taken_o
);
    localparam logic [PTR_W-1:0] STEP = PTR_W'(STRIDE);

    dce_state_e state_q, state_d;

    logic [STAT_W-1:0] stat_q;
    logic [SEL_W-1:0]  sel_q [NUM_DECISIONS];
    logic [CMD_W-1:0]  cmd_q;
    logic [PTR_W-1:0]  cur_q;
    logic [PTR_W-1:0]  dep_q;

    logic [NUM_DECISIONS-1:0] match;
    logic [NUM_DECISIONS-1:0] fire;
    logic [PTR_W-1:0]         ptr_calc;

    // input capture on the strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            cmd_q  <= '0;
            cur_q  <= '0;
            dep_q  <= '0;
            for (int i = 0; i < NUM_DECISIONS; i++) sel_q[i] <= '0;
        end else if (eval_i) begin
            stat_q            <= dev_stat_i;
            cmd_q             <= cmd_word_i;
            cur_q             <= cur_ptr_i;
            dep_q             <= dep_addr_i;
            sel_q[DEC_IRQ]    <= irq_sel_i;
            sel_q[DEC_BRANCH] <= br_sel_i;
            sel_q[DEC_WAIT]   <= wait_sel_i;
        end
    end

    // one condition and one mode decoder per decision
    for (genvar g = 0; g < NUM_DECISIONS; g++) begin : g_dec
        localparam int unsigned LSB = mode_lsb(g);

        dce_cond_match #(
            .STAT_W  (STAT_W),
            .SEL_W   (SEL_W),
            .MASK_LSB(MASK_LSB),
            .VAL_LSB (VAL_LSB)
        ) u_match (
            .stat_i (stat_q),
            .sel_i  (sel_q[g]),
            .match_o(match[g])
        );

        dce_mode_apply u_mode (
            .mode_i (cmd_q[LSB +: MODE_W]),
            .match_i(match[g]),
            .fire_o (fire[g])
        );
    end

    dce_ptr_next #(
        .PTR_W (PTR_W),
        .STRIDE(STRIDE)
    ) u_ptr (
        .cur_i (cur_q),
        .dep_i (dep_q),
        .take_i(fire[DEC_BRANCH]),
        .ptr_o (ptr_calc)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions: EVAL_START, EVAL_CHAIN, EVAL_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   state_d = eval_i ? S_DECIDE : S_IDLE;
            S_DECIDE: state_d = eval_i ? S_DECIDE : S_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o      <= 1'b0;
            wait_o     <= 1'b0;
            next_ptr_o <= '0;
            br_taken_o <= 1'b0;
        end else begin
            irq_o <= 1'b0;
            unique case (state_q)
                S_IDLE: ;
                S_DECIDE: begin
                    wait_o <= fire[DEC_WAIT];
                    if (fire[DEC_WAIT]) begin
                        next_ptr_o <= cur_q;
                    end else begin
                        irq_o      <= fire[DEC_IRQ];
                        next_ptr_o <= ptr_calc;
                        br_taken_o <= fire[DEC_BRANCH];
                    end
                end
            endcase
        end
    end

    AST_IRQ_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(eval_i, 2)) else $error("irq without strobe"); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |=> ($stable(next_ptr_o) && $stable(br_taken_o) && $stable(wait_o) && !irq_o))
        else $error("outputs moved while idle"); // R8

    AST_WAIT_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !wait_o) else $error("irq during wait"); // R7

    AST_STEP_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == S_DECIDE && !wait_o && !br_taken_o) |-> (next_ptr_o == $past(cur_q) + STEP))
        else $error("pointer step wrong"); // R5

    AST_WAIT_KEEPS_BT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DECIDE && fire[DEC_WAIT]) |=> $stable(br_taken_o))
        else $error("bt moved on wait"); // R7

endmodule

// File: tb/tb_dce_unit.sv
module tb_dce_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eval_i = 1'b0;
    logic [3:0]  dev_stat_i = '0;
    logic [31:0] irq_sel_i = '0, br_sel_i = '0, wait_sel_i = '0;
    logic [15:0] cmd_word_i = '0;
    logic [31:0] cur_ptr_i = '0, dep_addr_i = '0;
    logic        irq_o, wait_o, br_taken_o;
    logic [31:0] next_ptr_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] ex_ptr;
    logic        ex_bt, ex_wait, ex_irq;

    always #4 clk = ~clk;

    dce_unit dut (
        .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .dev_stat_i(dev_stat_i),
        .irq_sel_i(irq_sel_i), .br_sel_i(br_sel_i), .wait_sel_i(wait_sel_i),
        .cmd_word_i(cmd_word_i), .cur_ptr_i(cur_ptr_i), .dep_addr_i(dep_addr_i),
        .irq_o(irq_o), .wait_o(wait_o), .next_ptr_o(next_ptr_o), .br_taken_o(br_taken_o)
    );

    function automatic bit cond_f(input logic [3:0] st, input logic [31:0] sel);
        logic [3:0] m, v;
        m = sel[19:16];
        v = sel[3:0];
        return ((st & m) == (v & m));
    endfunction

    function automatic bit mode_f(input logic [1:0] md, input bit c);
        case (md)
            2'd0: return 1'b0;
            2'd1: return c;
            2'd2: return !c;
            default: return 1'b1;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // updates the expected model for one evaluation
    task automatic model(input logic [3:0] st, input logic [31:0] isel, input logic [31:0] bsel,
                         input logic [31:0] wsel, input logic [15:0] cmd,
                         input logic [31:0] cur, input logic [31:0] dep);
        bit fi, fb, fw;
        fi = mode_f(cmd[5:4], cond_f(st, isel));
        fb = mode_f(cmd[3:2], cond_f(st, bsel));
        fw = mode_f(cmd[1:0], cond_f(st, wsel));
        ex_wait = fw;
        if (fw) begin
            ex_irq = 1'b0;
            ex_ptr = cur;
        end else begin
            ex_irq = fi;
            ex_ptr = fb ? dep : cur + 32'd16;
            ex_bt  = fb;
        end
    endtask

    task automatic drive(input logic [3:0] st, input logic [31:0] isel, input logic [31:0] bsel,
                         input logic [31:0] wsel, input logic [15:0] cmd,
                         input logic [31:0] cur, input logic [31:0] dep);
        eval_i = 1'b1; dev_stat_i = st; irq_sel_i = isel; br_sel_i = bsel;
        wait_sel_i = wsel; cmd_word_i = cmd; cur_ptr_i = cur; dep_addr_i = dep;
    endtask

    task automatic scramble();
        eval_i = 1'b0; dev_stat_i = ~dev_stat_i; irq_sel_i = ~irq_sel_i;
        br_sel_i = ~br_sel_i; wait_sel_i = ~wait_sel_i; cmd_word_i = ~cmd_word_i;
        cur_ptr_i = cur_ptr_i ^ 32'h5555_0000; dep_addr_i = ~dep_addr_i;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R3 irq"}, {31'd0, irq_o}, {31'd0, ex_irq});
        chk({tag, " R6 wait"}, {31'd0, wait_o}, {31'd0, ex_wait});
        chk({tag, " R4/R5 ptr"}, next_ptr_o, ex_ptr);
        chk({tag, " R4/R5 bt"}, {31'd0, br_taken_o}, {31'd0, ex_bt});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] isel, bsel, wsel, cur, dep;
        logic [15:0] cmd;
        logic [31:0] p_hold;
        logic        b_hold, w_hold;
        ex_ptr = '0; ex_bt = 0; ex_wait = 0; ex_irq = 0;
        repeat (3) @(negedge clk);
        // R1 reset values
        check_all("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // sweep status x mask x value, modes cycle with the index (R2 R3 R4 R5 R6 R7)
        for (int idx = 0; idx < 4096; idx++) begin
            logic [3:0] st, mk, vl;
            st = idx[3:0]; mk = idx[7:4]; vl = idx[11:8];
            isel = {12'hA5C, mk, 12'h3F0, vl};
            bsel = {12'h0F0, mk ^ 4'h5, 12'hEA0, vl ^ 4'h3};
            wsel = {12'hFFF, ~mk, 12'h120, vl};
            cmd  = {idx[9:0], idx[1:0], idx[3:2], idx[5:4]};
            cur  = {16'h0010, idx[11:0], 4'h0};
            dep  = {16'h8000, ~idx[11:0], 4'h0};
            drive(st, isel, bsel, wsel, cmd, cur, dep);
            model(st, isel, bsel, wsel, cmd, cur, dep);
            @(posedge clk); @(negedge clk);
            scramble();
            @(posedge clk); @(negedge clk);
            check_all("R2 sweep");
        end

        // R3 irq pulse lasts one cycle; R8 idle hold with moving inputs
        drive(4'h0, 32'h0, 32'h0, 32'h0, 16'h0034, 32'h0000_1000, 32'h0000_2000);
        model(4'h0, 32'h0, 32'h0, 32'h0, 16'h0034, 32'h0000_1000, 32'h0000_2000);
        @(posedge clk); @(negedge clk);
        scramble();
        @(posedge clk); @(negedge clk);
        check_all("R3 always");
        p_hold = next_ptr_o; b_hold = br_taken_o; w_hold = wait_o;
        for (int k = 0; k < 6; k++) begin
            dev_stat_i = 4'(k); cmd_word_i = 16'hFFFF; cur_ptr_i = 32'(k * 7);
            irq_sel_i = 32'(k); dep_addr_i = 32'hDEAD_0000 + 32'(k);
            @(posedge clk); @(negedge clk);
            chk("R3 pulse width / R8 idle irq", {31'd0, irq_o}, 32'd0);
            chk("R8 idle ptr", next_ptr_o, p_hold);
            chk("R8 idle bt", {31'd0, br_taken_o}, {31'd0, b_hold});
            chk("R8 idle wait", {31'd0, wait_o}, {31'd0, w_hold});
        end

        // R7 wait keeps bt=1 from a prior branch
        drive(4'h0, 32'h0, 32'h0, 32'h0, 16'h000C, 32'h0000_3000, 32'h0000_4000);
        model(4'h0, 32'h0, 32'h0, 32'h0, 16'h000C, 32'h0000_3000, 32'h0000_4000);
        @(posedge clk); @(negedge clk); scramble(); @(posedge clk); @(negedge clk);
        check_all("R4 branch always");
        drive(4'h0, 32'h0, 32'h0, 32'h0, 16'h0033, 32'h0000_5000, 32'h0000_6000);
        model(4'h0, 32'h0, 32'h0, 32'h0, 16'h0033, 32'h0000_5000, 32'h0000_6000);
        @(posedge clk); @(negedge clk); scramble(); @(posedge clk); @(negedge clk);
        check_all("R7 wait holds bt");

        // R9 back-to-back strobes
        drive(4'h0, 32'h0, 32'h0, 32'h0, 16'h001C, 32'h0000_7000, 32'h0000_9000);
        @(posedge clk); @(negedge clk);
        drive(4'h0, 32'h0, 32'h0, 32'h0, 16'h0000, 32'h0000_A000, 32'h0000_B000);
        @(posedge clk); @(negedge clk);
        scramble();
        model(4'h0, 32'h0, 32'h0, 32'h0, 16'h001C, 32'h0000_7000, 32'h0000_9000);
        check_all("R9 first");
        @(posedge clk); @(negedge clk);
        model(4'h0, 32'h0, 32'h0, 32'h0, 16'h0000, 32'h0000_A000, 32'h0000_B000);
        check_all("R9 second");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule